// File: doc/BRIEF.md
# SPI Serial Memory Read Slave

This block is the serial front end of a byte-wide memory of 8192 locations. A host selects it by pulling chip select low and clocks in a one-byte command, most significant bit first. Two commands are served. The array read takes a 16-bit byte address after the command and then streams memory bytes back for as long as the serial clock keeps running. The status read returns one status byte, and it keeps returning it while the clock runs. The status byte carries a busy flag that reports an internal programming cycle. A status read is accepted while that flag is set.

The serial inputs are oversampled by the system clock through a two-stage synchronizer. Serial input bits are captured on rising serial clock edges. Output bits change on falling edges. The output driver is modelled as a data bit plus an enable, and a low enable means high impedance at the pad. The array is an internal synchronous RAM. It has a write port that a testbench uses to preload contents. The block accepts both idle clock levels: low (mode 0) and high (mode 3).

Top module: `spi_read_slave`

## Requirements
- R1: After reset, `spi_so_en` and `spi_so` are both 0.
- R2: `spi_so_en` stays low while the command byte and address bits are being clocked in.
- R3: Command value 8'h03 is followed by a 16-bit address, sent MSB first. Only the low 13 address bits select a location, and the upper 3 bits have no effect on which byte is returned.
- R4: The first data bit appears on `spi_so` after the falling clock edge that follows the last address bit. Each byte is sent MSB first, and `spi_so` changes only after a falling serial clock edge.
- R5: While chip select stays low and the clock keeps running, each further byte comes from the next higher address.
- R6: After address 8191 the stream continues from address 0, with no limit on its length.
- R7: Raising chip select ends any command at any point. `spi_so_en` drops within 3 system clocks, and the next selection starts again with a new command byte.
- R8: Command value 8'h05 returns the status byte `{stat_bits[6:0], wr_busy}`, with the busy flag in bit 0, MSB first. The byte is repeated for each further 8 clocks.
- R9: The status command is served normally while `wr_busy` is 1.
- R10: Any other command value leaves `spi_so_en` low until chip select goes high.
- R11: Reads work the same whether the serial clock idles low (mode 0) or high (mode 3).
- R12: A pulse on `ld_en` writes `ld_data` to location `ld_addr`, and a later array read returns that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in from the host |
| spi_so | output | 1 | Serial data out |
| spi_so_en | output | 1 | Output enable for `spi_so`; 0 means high impedance |
| stat_bits | input | 7 | Upper seven bits of the status byte |
| wr_busy | input | 1 | Busy flag of the internal write cycle, reported in status bit 0 |
| ld_en | input | 1 | Preload write strobe for the array |
| ld_addr | input | 13 | Preload address |
| ld_data | input | 8 | Preload data |

## Verification
The assertions assume that every serial clock half period lasts several system clocks, so the synchronizer, the phase register and the RAM read all settle between edges. They also assume that chip select stays high for a few system clocks between selections. The stimulus keeps each serial clock level for 8 system clocks and holds chip select high for at least 6 clocks between transactions. The bench uses the preload port only while chip select is high, so it never overwrites the byte that the read has already fetched.

// File: rtl/mr_pkg.sv
`timescale 1ns/1ps
package mr_pkg;

    localparam logic [7:0] OPC_ARRAY_RD  = 8'h03;
    localparam logic [7:0] OPC_STATUS_RD = 8'h05;
    localparam int         CMD_BITS      = 8;
    localparam int         ADDR_BITS_IN  = 16;

    typedef enum logic [2:0] {
        PH_CMD    = 3'd0,
        PH_ADDR   = 3'd1,
        PH_ARRAY  = 3'd2,
        PH_STATUS = 3'd3,
        PH_SKIP   = 3'd4
    } phase_e;

    typedef struct packed {
        logic [6:0] rest;
        logic [2:0] cnt;
        logic       bit_o;
        logic       en;
    } tx_t;

    function automatic phase_e classify(input logic [7:0] opc);
        if (opc == OPC_ARRAY_RD)       return PH_ADDR;
        else if (opc == OPC_STATUS_RD) return PH_STATUS;
        else                           return PH_SKIP;
    endfunction

    function automatic logic [7:0] pack_status(input logic [6:0] upper, input logic busy);
        return {upper, busy};
    endfunction

endpackage

// File: rtl/mr_sync.sv
`timescale 1ns/1ps
module mr_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/mr_mem.sv
`timescale 1ns/1ps
module mr_mem #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] arr [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) arr[wr_addr] <= wr_data;
        rd_data <= arr[rd_addr];
    end
endmodule

// File: rtl/mr_ctrl.sv
`timescale 1ns/1ps
module mr_ctrl
    import mr_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sck_s,
    input  logic          cs_n_s,
    input  logic          si_s,
    input  logic [7:0]    mem_q,
    input  logic [7:0]    stat_byte,
    output logic [AW-1:0] rd_ptr,
    output phase_e        phase,
    output logic          sck_fall,
    output logic          so_bit,
    output logic          so_en
);
    localparam int CNT_W = $clog2(ADDR_BITS_IN);

    logic             sck_prev;
    logic             sck_rise;
    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [14:0]      rx_sh;
    logic [15:0]      rx_nxt;
    logic [AW-1:0]    ptr_q;
    tx_t              tx_q;
    logic [7:0]       load_byte;
    logic             out_phase;

    assign sck_rise  = sck_s & ~sck_prev;
    assign sck_fall  = ~sck_s & sck_prev;
    assign rx_nxt    = {rx_sh, si_s};
    assign out_phase = (phase_q == PH_ARRAY) || (phase_q == PH_STATUS);
    assign load_byte = (phase_q == PH_ARRAY) ? mem_q : stat_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev <= 1'b0;
            phase_q  <= PH_CMD;
            cnt_q    <= '0;
            rx_sh    <= '0;
            ptr_q    <= '0;
            tx_q     <= '0;
        end else begin
            sck_prev <= sck_s;
            if (cs_n_s) begin
                phase_q <= PH_CMD;
                cnt_q   <= '0;
                tx_q.en <= 1'b0;
                tx_q.cnt <= '0;
            end else begin
                if (sck_rise) begin
                    case (phase_q)
                        PH_CMD: begin
                            rx_sh <= rx_nxt[14:0];
                            if (cnt_q == CNT_W'(CMD_BITS - 1)) begin
                                cnt_q   <= '0;
                                phase_q <= classify(rx_nxt[7:0]);
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                        PH_ADDR: begin
                            rx_sh <= rx_nxt[14:0];
                            if (cnt_q == CNT_W'(ADDR_BITS_IN - 1)) begin
                                cnt_q   <= '0;
                                ptr_q   <= AW'(rx_nxt);
                                phase_q <= PH_ARRAY;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
                if (sck_fall && out_phase) begin
                    tx_q.en  <= 1'b1;
                    tx_q.cnt <= tx_q.cnt + 1'b1;
                    if (tx_q.cnt == 3'd0) begin
                        tx_q.bit_o <= load_byte[7];
                        tx_q.rest  <= load_byte[6:0];
                        if (phase_q == PH_ARRAY) ptr_q <= ptr_q + 1'b1;
                    end else begin
                        tx_q.bit_o <= tx_q.rest[6];
                        tx_q.rest  <= {tx_q.rest[5:0], 1'b0};
                    end
                end
            end
        end
    end

    assign rd_ptr = ptr_q;
    assign phase  = phase_q;
    assign so_bit = tx_q.bit_o;
    assign so_en  = tx_q.en;
endmodule

// File: rtl/spi_read_slave.sv
`timescale 1ns/1ps
module spi_read_slave
    import mr_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          spi_sck,
    input  logic          spi_cs_n,
    input  logic          spi_si,
    output logic          spi_so,
    output logic          spi_so_en,
    input  logic [6:0]    stat_bits,
    input  logic          wr_busy,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [7:0]    ld_data
);
    logic [2:0]    pins_s;
    logic [AW-1:0] rd_ptr;
    logic [7:0]    mem_q;
    phase_e        phase;
    logic          sck_fall;

    mr_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_cs_n, spi_sck, spi_si}),
        .q   (pins_s)
    );

    mr_mem #(.AW(AW), .DW(8)) u_mem (
        .clk     (clk),
        .wr_en   (ld_en),
        .wr_addr (ld_addr),
        .wr_data (ld_data),
        .rd_addr (rd_ptr),
        .rd_data (mem_q)
    );

    mr_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sck_s     (pins_s[1]),
        .cs_n_s    (pins_s[2]),
        .si_s      (pins_s[0]),
        .mem_q     (mem_q),
        .stat_byte (pack_status(stat_bits, wr_busy)),
        .rd_ptr    (rd_ptr),
        .phase     (phase),
        .sck_fall  (sck_fall),
        .so_bit    (spi_so),
        .so_en     (spi_so_en)
    );
endmodule

// File: rtl/mr_checker.sv
`timescale 1ns/1ps
module mr_checker
    import mr_pkg::*;
#(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          rst,
    input logic          spi_cs_n,
    input logic          spi_so,
    input logic          spi_so_en,
    input logic          sck_fall,
    input phase_e        phase,
    input logic [AW-1:0] rd_ptr
);
    p_quiet_deselected_r7: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_so_en);

    p_so_moves_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(spi_so) |-> $past(sck_fall));

    p_no_drive_in_command_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CMD || phase == PH_ADDR) |-> !spi_so_en);

    p_skip_stays_silent_r10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP) |-> !spi_so_en);

    p_ptr_steps_one_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ARRAY && $past(phase) == PH_ARRAY && rd_ptr != $past(rd_ptr))
        |-> rd_ptr == AW'($past(rd_ptr) + 1'b1));
endmodule

bind spi_read_slave mr_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .spi_cs_n  (spi_cs_n),
    .spi_so    (spi_so),
    .spi_so_en (spi_so_en),
    .sck_fall  (sck_fall),
    .phase     (phase),
    .rd_ptr    (rd_ptr)
);

// File: tb/sim_spi_read_slave.sv
`timescale 1ns/1ps
module sim_spi_read_slave;
    localparam int AW   = 13;
    localparam int HALF = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          spi_sck = 1'b0;
    logic          spi_cs_n = 1'b1;
    logic          spi_si = 1'b0;
    logic          spi_so;
    logic          spi_so_en;
    logic [6:0]    stat_bits = '0;
    logic          wr_busy = 1'b0;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [7:0]    ld_data = '0;

    logic [7:0] ref_mem [1 << AW];
    logic [7:0] rx_buf [16];
    int n_checks = 0;
    int n_errors = 0;
    int en_early, en_missing, en_any;
    bit done = 0;

    always #4 clk = ~clk;

    spi_read_slave #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_si(spi_si),
        .spi_so(spi_so), .spi_so_en(spi_so_en), .stat_bits(stat_bits), .wr_busy(wr_busy),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_array(input logic [15:0] a, input int k);
        logic [AW-1:0] idx;
        idx = AW'(a) + AW'(k);
        return ref_mem[idx];
    endfunction

    function automatic logic [7:0] exp_status();
        return {stat_bits, wr_busy};
    endfunction

    task automatic load(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
        ref_mem[a] = d;
    endtask

    task automatic spi_bit(input logic b, output logic sb, output logic se);
        @(negedge clk);
        spi_sck = 1'b0;
        spi_si  = b;
        repeat (HALF) @(negedge clk);
        sb = spi_so;
        se = spi_so_en;
        spi_sck = 1'b1;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic spi_txn(input bit m3, input logic [7:0] opc, input bit with_addr,
                           input logic [15:0] addr, input int nrx, input int cut_bits);
        int  total;
        logic b, sb, se;
        en_early = 0; en_missing = 0; en_any = 0;
        @(negedge clk);
        spi_sck = m3;
        repeat (4) @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        total = with_addr ? 24 : 8;
        if (cut_bits > 0 && cut_bits < total) total = cut_bits;
        for (int i = 0; i < total; i++) begin
            b = (i < 8) ? opc[7 - i] : addr[15 - (i - 8)];
            spi_bit(b, sb, se);
            if (se) en_early++;
        end
        if (cut_bits == 0) begin
            for (int k = 0; k < nrx; k++) begin
                for (int j = 0; j < 8; j++) begin
                    spi_bit(1'($urandom), sb, se);
                    rx_buf[k][7 - j] = sb;
                    if (!se) en_missing++;
                    if (se) en_any++;
                end
            end
        end
        @(negedge clk);
        spi_sck = m3;
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic read_check(input bit m3, input logic [15:0] addr, input int n, input string req);
        spi_txn(m3, 8'h03, 1'b1, addr, n, 0);
        for (int k = 0; k < n; k++)
            chk(rx_buf[k] == exp_array(addr, k), req, "array byte", rx_buf[k], exp_array(addr, k));
        chk(en_early == 0, "R2", "enable during command", en_early, 0);
        chk(en_missing == 0, req, "enable missing in data", en_missing, 0);
        chk(spi_so_en == 1'b0, "R7", "enable after deselect", spi_so_en, 0);
    endtask

    task automatic status_check(input bit m3, input int n, input string req);
        spi_txn(m3, 8'h05, 1'b0, 16'h0, n, 0);
        for (int k = 0; k < n; k++)
            chk(rx_buf[k] == exp_status(), req, "status byte", rx_buf[k], exp_status());
        chk(en_early == 0, "R2", "enable during command", en_early, 0);
        chk(en_missing == 0, req, "enable missing in status", en_missing, 0);
    endtask

    initial begin
        void'($urandom(32'd17));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(spi_so_en == 1'b0, "R1", "so_en after reset", spi_so_en, 0);
        chk(spi_so == 1'b0, "R1", "so after reset", spi_so, 0);

        for (int a = 0; a < (1 << AW); a++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = AW'(a); ld_data = 8'($urandom);
            ref_mem[a] = ld_data;
        end
        @(negedge clk);
        ld_en = 1'b0;

        read_check(1'b0, 16'h0000, 4, "R5");
        read_check(1'b0, 16'hE005, 2, "R3");
        read_check(1'b1, 16'h1FFE, 4, "R6");
        read_check(1'b1, 16'h0123, 3, "R11");
        read_check(1'b0, 16'h1FFF, 3, "R4");

        stat_bits = 7'h5A; wr_busy = 1'b0;
        status_check(1'b0, 2, "R8");
        stat_bits = 7'h13; wr_busy = 1'b1;
        status_check(1'b1, 2, "R9");

        spi_txn(1'b0, 8'h0B, 1'b0, 16'h0, 3, 0);
        chk(en_any == 0, "R10", "enable after unknown command", en_any, 0);
        read_check(1'b0, 16'h0040, 1, "R10");

        spi_txn(1'b1, 8'h03, 1'b1, 16'h0ABC, 0, 14);
        chk(spi_so_en == 1'b0, "R7", "enable after aborted address", spi_so_en, 0);
        read_check(1'b1, 16'h0200, 2, "R7");

        load(13'h0777, 8'hC3);
        read_check(1'b0, 16'h0777, 1, "R12");

        for (int t = 0; t < 10; t++) begin
            if ($urandom % 3 == 0) begin
                stat_bits = 7'($urandom); wr_busy = 1'($urandom);
                status_check(1'($urandom), 1 + int'($urandom % 3), "R8");
            end else begin
                read_check(1'($urandom), 16'($urandom), 1 + int'($urandom % 5), "R5");
            end
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule